// File: doc/BRIEF.md
# Zero-Data AXI4 Memory Sink

This block is an AXI4 slave that looks like a memory whose contents are zero and can never change. A read burst returns the requested number of beats, each carrying all-zero data, the ID of the request and an OKAY response. A write burst is accepted beat by beat, its data is thrown away, and one write response closes it. The block fits wherever a bus needs a harmless target, such as a default slave for unmapped address space or a drain for traffic that nobody consumes.

Read beats and write beats go through a single shared access slot. An arbiter hands that slot out one beat per cycle. When both directions want it, the grants alternate between them. A read beat that wins the slot is placed in a small response buffer, and the R channel is served from that buffer. Read beats stop being issued while the buffer is full. A busy flag is raised whenever any request is still being handled.

Top module: `zero_mem_sink`

## Requirements
- R1: Every R beat carries all-zero data on each of the NUM_LANES equal data lanes, and RRESP = 2'b00 (OKAY). This holds whatever the address and whatever data was written before.
- R2: A read request with length field L produces exactly L+1 R beats. Every beat carries RID equal to the request ID, and RLAST is 1 only on the final beat.
- R3: The response buffer never takes a beat while it is full, and no beat is lost or reordered when the R channel stalls for longer than the buffer depth.
- R4: While r_valid_o is 1 and r_ready_i is 0, r_valid_o stays 1 and RID, RLAST and RDATA hold their values on the next cycle.
- R5: Every offered W beat of an accepted write burst is eventually accepted. Exactly one B response follows the beat carrying WLAST, with BID equal to the write request ID and BRESP = 2'b00. No B appears before that beat.
- R6: b_valid_o and b_id_o hold until b_ready_i is seen. No new write request is accepted while a write burst or its response is outstanding.
- R7: When read and write beats are both pending, grants alternate each cycle. A write burst and a read burst of eight beats each, started together with no backpressure, both complete with their first and last beats 14 cycles apart.
- R8: FIXED (2'b00), INCR (2'b01) and WRAP (2'b10) bursts are all sequenced with the same beat count. FIXED keeps the beat address constant, and the address never affects the data.
- R9: busy_o is 1 while any request is in flight or any response is still owed, and 0 when idle. When idle, both address channels are ready.
- R10: The reset is asynchronous and active low. After reset no R or B response is valid, w_ready_o is 0, and ar_ready_o and aw_ready_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_o | output | 1 | A request is in flight |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| aw_id_i | input | ID_W | Write request ID |
| aw_addr_i | input | ADDR_W | Write start address |
| aw_len_i | input | 8 | Write beats minus one |
| aw_size_i | input | 3 | Write beat size, log2 bytes |
| aw_burst_i | input | 2 | Write burst type |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| w_data_i | input | DATA_W | Write data (discarded) |
| w_strb_i | input | DATA_W/8 | Write byte strobes (discarded) |
| w_last_i | input | 1 | Final write beat |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| b_id_o | output | ID_W | Write response ID |
| b_resp_o | output | 2 | Write response code |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| ar_id_i | input | ID_W | Read request ID |
| ar_addr_i | input | ADDR_W | Read start address |
| ar_len_i | input | 8 | Read beats minus one |
| ar_size_i | input | 3 | Read beat size, log2 bytes |
| ar_burst_i | input | 2 | Read burst type |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_id_o | output | ID_W | Read response ID |
| r_data_o | output | DATA_W | Read data, always zero |
| r_resp_o | output | 2 | Read response code |
| r_last_o | output | 1 | Final read beat |

## Verification
A wrong beat counter inside a sequencer shows at the ports on the affected burst: RLAST arrives a cycle early or late, or the total number of R beats is wrong, and the bench counts both. A stuck arbiter priority shows within a few cycles of concurrent traffic, because the spacing between accepted W beats no longer matches the alternating schedule. A response buffer that drops or repeats an entry under a long stall breaks the beat count or the RLAST position of that same burst. A write response state that is never cleared, or is set too early, blocks the next write address or raises b_valid_o during the data phase, and this is caught on the next burst.

// File: rtl/zms_pkg.sv
package zms_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  typedef logic [7:0] len_t;
  typedef logic [2:0] size_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/zms_burst_seq.sv
module zms_burst_seq
  import zms_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  len_t              len_i,
  input  size_t             size_i,
  input  logic [1:0]        burst_i,
  input  logic              step_i,
  output logic              active_o,
  output logic [ID_W-1:0]   id_o,
  output logic              last_o
);
  logic              active_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  len_t              len_q, cnt_q;
  size_t             size_q;
  burst_e            burst_q;
  logic [ADDR_W-1:0] inc, wrap_mask;

  assign inc       = ADDR_W'(1) << size_q;
  assign wrap_mask = ((ADDR_W'(len_q) + ADDR_W'(1)) << size_q) - ADDR_W'(1);

  always_comb begin
    unique case (burst_q)
      BURST_FIXED: addr_nxt = addr_q;
      BURST_WRAP:  addr_nxt = (addr_q & ~wrap_mask) | ((addr_q + inc) & wrap_mask);
      default:     addr_nxt = addr_q + inc;
    endcase
  end

  assign active_o = active_q;
  assign id_o     = id_q;
  assign last_o   = (cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      id_q     <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      size_q   <= '0;
      burst_q  <= BURST_INCR;
    end else if (start_i) begin
      active_q <= 1'b1;
      id_q     <= id_i;
      addr_q   <= addr_i;
      len_q    <= len_i;
      cnt_q    <= '0;
      size_q   <= size_i;
      burst_q  <= burst_e'(burst_i);
    end else if (step_i && active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + len_t'(1);
        addr_q <= addr_nxt;
      end
    end
  end

  // R2: a new burst only starts once the previous one is finished
  a_r2_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R8: FIXED bursts keep the beat address
  a_r8_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && step_i && !last_o && burst_q == BURST_FIXED) |=> addr_q == $past(addr_q));
endmodule

// File: rtl/zms_arbiter.sv
module zms_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  output logic rd_gnt_o,
  output logic wr_gnt_o
);
  logic last_rd_q;

  assign rd_gnt_o = rd_req_i && (!wr_req_i || !last_rd_q);
  assign wr_gnt_o = wr_req_i && (!rd_req_i || last_rd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    last_rd_q <= 1'b0;
    else if (rd_gnt_o || wr_gnt_o)  last_rd_q <= rd_gnt_o;
  end

  a_r7_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_gnt_o, wr_gnt_o}));
  a_r7_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i && rd_gnt_o) |=> (!(rd_req_i && wr_req_i) || wr_gnt_o));
  a_r7_wr_then_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i && wr_gnt_o) |=> (!(rd_req_i && wr_req_i) || rd_gnt_o));
endmodule

// File: rtl/zms_rsp_buf.sv
module zms_rsp_buf #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_ptr_q] <= din_i;
        wr_ptr_q        <= ptr_inc(wr_ptr_q);
      end
      if (pop_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (!push_i && pop_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/zero_mem_sink.sv
module zero_mem_sink
  import zms_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned RSP_DEPTH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                busy_o,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [ID_W-1:0]     aw_id_i,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [7:0]          aw_len_i,
  input  logic [2:0]          aw_size_i,
  input  logic [1:0]          aw_burst_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  output logic                b_valid_o,
  input  logic                b_ready_i,
  output logic [ID_W-1:0]     b_id_o,
  output logic [1:0]          b_resp_o,
  input  logic                ar_valid_i,
  output logic                ar_ready_o,
  input  logic [ID_W-1:0]     ar_id_i,
  input  logic [ADDR_W-1:0]   ar_addr_i,
  input  logic [7:0]          ar_len_i,
  input  logic [2:0]          ar_size_i,
  input  logic [1:0]          ar_burst_i,
  output logic                r_valid_o,
  input  logic                r_ready_i,
  output logic [ID_W-1:0]     r_id_o,
  output logic [DATA_W-1:0]   r_data_o,
  output logic [1:0]          r_resp_o,
  output logic                r_last_o
);
  localparam int unsigned LANE_W = DATA_W / NUM_LANES;
  localparam int unsigned ENT_W  = ID_W + 1;

  logic            rd_active, wr_active, rd_last, wr_last;
  logic [ID_W-1:0] rd_id, wr_id;
  logic            rd_req, wr_req, rd_gnt, wr_gnt;
  logic            ar_hs, aw_hs;
  logic            buf_empty, buf_full;
  logic [ENT_W-1:0] buf_dout;
  logic            b_pend_q;
  logic [ID_W-1:0] b_id_q;

  assign ar_ready_o = !rd_active;
  assign aw_ready_o = !wr_active && !b_pend_q;
  assign ar_hs      = ar_valid_i && ar_ready_o;
  assign aw_hs      = aw_valid_i && aw_ready_o;

  zms_burst_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_rd_seq (
    .clk_i, .rst_ni,
    .start_i (ar_hs),    .id_i   (ar_id_i),   .addr_i  (ar_addr_i),
    .len_i   (ar_len_i), .size_i (ar_size_i), .burst_i (ar_burst_i),
    .step_i  (rd_gnt),
    .active_o(rd_active), .id_o (rd_id), .last_o (rd_last)
  );

  zms_burst_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_wr_seq (
    .clk_i, .rst_ni,
    .start_i (aw_hs),    .id_i   (aw_id_i),   .addr_i  (aw_addr_i),
    .len_i   (aw_len_i), .size_i (aw_size_i), .burst_i (aw_burst_i),
    .step_i  (wr_gnt),
    .active_o(wr_active), .id_o (wr_id), .last_o (wr_last)
  );

  // read beats stall on a full buffer; write beats need W data present
  assign rd_req = rd_active && !buf_full;
  assign wr_req = wr_active && w_valid_i;

  zms_arbiter u_arb (
    .clk_i, .rst_ni,
    .rd_req_i(rd_req), .wr_req_i(wr_req),
    .rd_gnt_o(rd_gnt), .wr_gnt_o(wr_gnt)
  );

  assign w_ready_o = wr_gnt;

  zms_rsp_buf #(.WIDTH(ENT_W), .DEPTH(RSP_DEPTH)) u_rsp_buf (
    .clk_i, .rst_ni,
    .push_i (rd_gnt),
    .din_i  ({rd_id, rd_last}),
    .pop_i  (r_valid_o && r_ready_i),
    .dout_o (buf_dout),
    .empty_o(buf_empty),
    .full_o (buf_full)
  );

  assign r_valid_o = !buf_empty;
  assign r_id_o    = buf_dout[ENT_W-1:1];
  assign r_last_o  = buf_dout[0];
  assign r_resp_o  = RESP_OKAY;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign r_data_o[l*LANE_W +: LANE_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_pend_q <= 1'b0;
      b_id_q   <= '0;
    end else if (wr_gnt && w_last_i) begin
      b_pend_q <= 1'b1;
      b_id_q   <= wr_id;
    end else if (b_valid_o && b_ready_i) begin
      b_pend_q <= 1'b0;
    end
  end

  assign b_valid_o = b_pend_q;
  assign b_id_o    = b_id_q;
  assign b_resp_o  = RESP_OKAY;

  assign busy_o = rd_active || wr_active || !buf_empty || b_pend_q;

  a_r4_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(r_id_o) && $stable(r_last_o) && $stable(r_data_o)));
  a_r6_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_o && !b_ready_i) |=> (b_valid_o && $stable(b_id_o)));
  a_r6_no_aw_while_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> !aw_ready_o);
  a_r5_wlast_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gnt |-> (w_last_i == wr_last));
  a_r5_w_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_i && w_ready_o) |-> !$isunknown({w_data_i, w_strb_i}));
  a_r9_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ar_ready_o && aw_ready_o && !r_valid_o && !b_valid_o));
endmodule

// File: tb/zero_mem_sink_bench.sv
module zero_mem_sink_bench;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned ID_W   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic busy_o;
  logic aw_valid_i = 0, aw_ready_o;
  logic [ID_W-1:0] aw_id_i = '0;
  logic [ADDR_W-1:0] aw_addr_i = '0;
  logic [7:0] aw_len_i = '0;
  logic [2:0] aw_size_i = '0;
  logic [1:0] aw_burst_i = '0;
  logic w_valid_i = 0, w_ready_o;
  logic [DATA_W-1:0] w_data_i = '0;
  logic [DATA_W/8-1:0] w_strb_i = '0;
  logic w_last_i = 0;
  logic b_valid_o, b_ready_i = 0;
  logic [ID_W-1:0] b_id_o;
  logic [1:0] b_resp_o;
  logic ar_valid_i = 0, ar_ready_o;
  logic [ID_W-1:0] ar_id_i = '0;
  logic [ADDR_W-1:0] ar_addr_i = '0;
  logic [7:0] ar_len_i = '0;
  logic [2:0] ar_size_i = '0;
  logic [1:0] ar_burst_i = '0;
  logic r_valid_o, r_ready_i = 0;
  logic [ID_W-1:0] r_id_o;
  logic [DATA_W-1:0] r_data_o;
  logic [1:0] r_resp_o;
  logic r_last_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int w_first, w_lastc, r_first, r_lastc;

  always #5 clk_i = ~clk_i;

  zero_mem_sink u_zero_mem_sink (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bp: 0 = always ready, 1 = random, 2 = long stall then ready
  task automatic rd_burst(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                          input logic [7:0] len, input logic [2:0] size,
                          input logic [1:0] burst, input int bp);
    int n = 0, it = 0;
    bit stalled = 0, hs;
    logic [ID_W-1:0] pid = '0;
    logic plast = 0;
    ar_valid_i = 1; ar_id_i = id; ar_addr_i = addr; ar_len_i = len;
    ar_size_i = size; ar_burst_i = burst;
    forever begin
      #1; hs = ar_ready_o;
      @(negedge clk_i);
      if (hs) break;
    end
    ar_valid_i = 0;
    while (n <= int'(len)) begin
      r_ready_i = (bp == 0) ? 1'b1 : (bp == 1) ? 1'($urandom_range(0, 1)) : (it >= 10);
      #1;
      if (stalled) begin
        chk(r_valid_o && r_id_o == pid && r_last_o == plast, "R4", "hold under stall",
            {r_valid_o, r_id_o, r_last_o}, {1'b1, pid, plast});
      end
      stalled = r_valid_o && !r_ready_i;
      pid = r_id_o; plast = r_last_o;
      if (r_valid_o && r_ready_i) begin
        chk(r_data_o == '0, "R1", "read data zero", r_data_o, 64'd0);
        chk(r_resp_o == 2'b00, "R1", "read resp okay", r_resp_o, 2'b00);
        chk(r_id_o == id, "R2", "read id", r_id_o, id);
        chk(r_last_o == (n == int'(len)), bp == 2 ? "R3" : "R2", "read last position",
            r_last_o, (n == int'(len)));
        if (n == 0) r_first = cyc;
        r_lastc = cyc;
        n++;
      end
      it++;
      @(negedge clk_i);
    end
    r_ready_i = 0;
    #1;
    chk(!r_valid_o, "R2", "no extra read beat", r_valid_o, 0);
  endtask

  task automatic wr_burst(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                          input logic [7:0] len, input logic [2:0] size,
                          input logic [1:0] burst, input bit rnd);
    int n = 0;
    bit hs, done = 0;
    aw_valid_i = 1; aw_id_i = id; aw_addr_i = addr; aw_len_i = len;
    aw_size_i = size; aw_burst_i = burst;
    w_valid_i = 1; w_data_i = {$urandom, $urandom}; w_strb_i = '1; w_last_i = (len == 0);
    forever begin
      #1; hs = aw_ready_o;
      @(negedge clk_i);
      if (hs) break;
    end
    aw_valid_i = 0;
    while (n <= int'(len)) begin
      w_valid_i = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      w_data_i = {$urandom, $urandom};
      w_strb_i = 8'($urandom);
      w_last_i = (n == int'(len));
      #1;
      chk(!b_valid_o, "R5", "no early B", b_valid_o, 0);
      if (w_valid_i && w_ready_o) begin
        if (n == 0) w_first = cyc;
        w_lastc = cyc;
        n++;
      end
      @(negedge clk_i);
    end
    w_valid_i = 0; w_last_i = 0;
    while (!done) begin
      b_ready_i = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      #1;
      if (b_valid_o && !b_ready_i) begin
        chk(!aw_ready_o, "R6", "aw blocked while B owed", aw_ready_o, 0);
        chk(busy_o, "R9", "busy while B owed", busy_o, 1);
      end
      if (b_valid_o && b_ready_i) begin
        chk(b_id_o == id, "R5", "B id", b_id_o, id);
        chk(b_resp_o == 2'b00, "R5", "B resp okay", b_resp_o, 2'b00);
        done = 1;
      end
      @(negedge clk_i);
    end
    b_ready_i = 0;
    #1;
    chk(!b_valid_o, "R5", "single B", b_valid_o, 0);
  endtask

  function automatic logic [7:0] pick_len(input logic [1:0] burst);
    if (burst == 2'b10) return 8'((2 << $urandom_range(0, 3)) - 1);
    return 8'($urandom_range(0, 15));
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    #23;
    #1;
    chk(!r_valid_o && !b_valid_o && !w_ready_o, "R10", "outputs idle in reset",
        {r_valid_o, b_valid_o, w_ready_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    chk(ar_ready_o && aw_ready_o && !busy_o, "R10", "ready after reset",
        {ar_ready_o, aw_ready_o, busy_o}, 3'b110);
    @(negedge clk_i);

    // directed: each burst type, R8
    for (int b = 0; b < 3; b++) begin
      wr_burst(4'(b + 1), 32'h100, 8'd3, 3'd3, 2'(b), 0);
      rd_burst(4'(b + 5), 32'h100, 8'd3, 3'd3, 2'(b), 0);
      chk(r_lastc - r_first == 3, "R8", "burst type beat count", r_lastc - r_first, 3);
    end
    // single-beat read and write
    rd_burst(4'hA, 32'h0, 8'd0, 3'd2, 2'b01, 0);
    wr_burst(4'hB, 32'h0, 8'd0, 3'd2, 2'b01, 0);
    // long stall beyond buffer depth, R3
    rd_burst(4'hC, 32'h40, 8'd7, 3'd3, 2'b01, 2);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      logic [1:0] bt;
      logic [2:0] sz;
      bt = 2'($urandom_range(0, 2));
      sz = 3'($urandom_range(0, 3));
      if (i % 2 == 0)
        wr_burst(4'($urandom), 32'($urandom) & ~32'h3f, pick_len(bt), sz, bt, 1);
      else
        rd_burst(4'($urandom), 32'($urandom) & ~32'h3f, pick_len(bt), sz, bt, 1);
    end

    // concurrent read and write, R7
    fork
      wr_burst(4'h3, 32'h200, 8'd7, 3'd3, 2'b01, 0);
      rd_burst(4'h9, 32'h200, 8'd7, 3'd3, 2'b01, 0);
    join
    chk(w_lastc - w_first == 14, "R7", "write beats alternate", w_lastc - w_first, 14);
    chk(r_lastc - r_first == 14, "R7", "read beats alternate", r_lastc - r_first, 14);

    @(negedge clk_i);
    #1;
    chk(!busy_o && ar_ready_o && aw_ready_o, "R9", "idle at end",
        {busy_o, ar_ready_o, aw_ready_o}, 3'b011);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule